// File: doc/BRIEF.md
# Guarded Issue Predicate Bank with Speculation Poison

This block keeps a bank of one-bit condition flags and gates each issued operation on one of them. A compare unit writes its outcome into a pair of flags per cycle. The first named flag gets the outcome and the second gets its inverse, so both arms of an if/else can be guarded without a branch. Every issued operation names a guard flag. When that flag is false, the block turns the operation into a no-op: no commit, no register write and no redirect.

The block also keeps one poison bit per general register, for loads that are hoisted above a branch. Such a load never traps. On a fault it writes its destination and marks it poisoned. A later check operation on that register asks for a redirect to a fixup address while the poison bit is set. An ordinary write to the register clears the bit. All results leave the block from registers one cycle after issue.

Top module: `pred_guard_unit`

## Requirements
- R1: After synchronous reset, every flag other than flag 0 reads false, every poison bit is clear, and all registered outputs are low.
- R2: Flag 0 always reads true. A compare that names it as either destination leaves it true.
- R3: A compare with `cmp_valid` high writes `cmp_result` to flag `cmp_dst_t` and its inverse to flag `cmp_dst_f`. An issue in any later cycle sees the new values.
- R4: An issue in the same cycle as a compare sees the value that the compare is writing to its guard flag.
- R5: When `cmp_dst_t` equals `cmp_dst_f`, that flag takes `cmp_result`.
- R6: An issue whose guard flag is false gives `commit_en`, `wb_en` and `redirect_en` all low, and it changes no poison bit.
- R7: A guarded-on plain write (`iss_kind`=1) gives `wb_en`=1, `wb_rd`=`iss_rd` and `wb_poison`=0, and it clears the destination's poison bit.
- R8: A guarded-on speculative load (`iss_kind`=2) gives `wb_en`=1 and `wb_poison`=`iss_fault`. The destination's poison bit becomes `iss_fault`.
- R9: A guarded-on check (`iss_kind`=3) raises `redirect_en` with `redirect_addr`=`iss_fixup` exactly when the named register is poisoned. The check changes no poison bit. An operation with `iss_kind`=0 writes no register.
- R10: A write or load that its guard turns off leaves the destination's poison bit as it was.
- R11: Every output reflects the issue of the previous clock edge. No output changes combinationally with the issue inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | Compare result write strobe |
| cmp_dst_t | input | 6 | Flag that receives the compare outcome |
| cmp_dst_f | input | 6 | Flag that receives the inverted outcome |
| cmp_result | input | 1 | Compare outcome |
| iss_valid | input | 1 | An operation issues this cycle |
| iss_qp | input | 6 | Guard flag index |
| iss_kind | input | 2 | 0 other, 1 plain write, 2 speculative load, 3 check |
| iss_rd | input | 7 | General register written or checked |
| iss_fault | input | 1 | Speculative load hit a fault |
| iss_fixup | input | 32 | Fixup address for a check |
| commit_en | output | 1 | Operation commits (guard true) |
| wb_en | output | 1 | Register write enable |
| wb_rd | output | 7 | Register written |
| wb_poison | output | 1 | Written value carries poison |
| redirect_en | output | 1 | Check found poison: redirect control |
| redirect_addr | output | 32 | Redirect target |

## Verification
The guard read and the compare write can fall in the same cycle. The bench provokes this by driving a compare and an issue together, with the guard index equal to either compare destination. It judges the result from `commit_en` one cycle later, against the value that the requirements give for the new flag. Poison state is hidden, so it is brought out through check operations, which also cover a guarded-off write that lands on a poisoned register.

// File: rtl/pgu_pkg.sv
package pgu_pkg;
  typedef enum logic [1:0] {
    OPK_OTHER = 2'd0,
    OPK_WRITE = 2'd1,
    OPK_SPECLD = 2'd2,
    OPK_CHECK = 2'd3
  } op_kind_e;
endpackage

// File: rtl/pgu_flag_bank.sv
module pgu_flag_bank #(
  parameter int NPRED = 64,
  localparam int PIW = $clog2(NPRED)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmp_valid,
  input  logic [PIW-1:0] cmp_dst_t,
  input  logic [PIW-1:0] cmp_dst_f,
  input  logic           cmp_result,
  input  logic [PIW-1:0] rd_idx,
  output logic           rd_val
);
  logic [NPRED-1:0] flags;

  // flag 0 is a constant true; others take the true-sense write first
  for (genvar i = 0; i < NPRED; i++) begin : g_flag
    if (i == 0) begin : g_const
      assign flags[i] = 1'b1;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          flags[i] <= 1'b0;
        end else if (cmp_valid && cmp_dst_t == PIW'(i)) begin
          flags[i] <= cmp_result;
        end else if (cmp_valid && cmp_dst_f == PIW'(i)) begin
          flags[i] <= ~cmp_result;
        end
      end
    end
  end

  // read with forwarding of the compare being written this cycle
  always_comb begin
    rd_val = flags[rd_idx];
    if (cmp_valid && rd_idx != '0) begin
      if (cmp_dst_t == rd_idx) begin
        rd_val = cmp_result;
      end else if (cmp_dst_f == rd_idx) begin
        rd_val = ~cmp_result;
      end
    end
  end

  p_zero_true_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == '0) |-> rd_val);

  p_pair_r3: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_dst_t != cmp_dst_f && cmp_dst_t != '0 && cmp_dst_f != '0)
    |=> (flags[$past(cmp_dst_t)] == $past(cmp_result)) &&
        (flags[$past(cmp_dst_f)] == !$past(cmp_result)));

  p_alias_r5: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_dst_t == cmp_dst_f && cmp_dst_t != '0)
    |=> flags[$past(cmp_dst_t)] == $past(cmp_result));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cmp_valid |=> $stable(flags));
endmodule

// File: rtl/pgu_poison_bank.sv
module pgu_poison_bank #(
  parameter int NGPR = 128,
  localparam int GIW = $clog2(NGPR)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [GIW-1:0] wr_idx,
  input  logic           wr_val,
  input  logic [GIW-1:0] rd_idx,
  output logic           rd_val
);
  logic [NGPR-1:0] poison;

  always_ff @(posedge clk) begin
    if (rst) begin
      poison <= '0;
    end else if (we) begin
      poison[wr_idx] <= wr_val;
    end
  end

  assign rd_val = poison[rd_idx];

  p_write_r8: assert property (@(posedge clk) disable iff (rst)
    we |=> poison[$past(wr_idx)] == $past(wr_val));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(poison));
endmodule

// File: rtl/pgu_issue_gate.sv
module pgu_issue_gate
  import pgu_pkg::*;
#(
  parameter int NGPR = 128,
  parameter int AW = 32,
  localparam int GIW = $clog2(NGPR)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           iss_valid,
  input  op_kind_e       iss_kind,
  input  logic [GIW-1:0] iss_rd,
  input  logic           iss_fault,
  input  logic [AW-1:0]  iss_fixup,
  input  logic           guard_val,
  input  logic           pz_rd_val,
  output logic           pz_we,
  output logic           pz_val,
  output logic           commit_en,
  output logic           wb_en,
  output logic [GIW-1:0] wb_rd,
  output logic           wb_poison,
  output logic           redirect_en,
  output logic [AW-1:0]  redirect_addr
);
  logic go;
  logic writes_reg;

  assign go         = iss_valid && guard_val;
  assign writes_reg = (iss_kind == OPK_WRITE) || (iss_kind == OPK_SPECLD);
  assign pz_we      = go && writes_reg;
  assign pz_val     = (iss_kind == OPK_SPECLD) && iss_fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_en     <= 1'b0;
      wb_en         <= 1'b0;
      wb_rd         <= '0;
      wb_poison     <= 1'b0;
      redirect_en   <= 1'b0;
      redirect_addr <= '0;
    end else begin
      commit_en     <= go;
      wb_en         <= go && writes_reg;
      wb_rd         <= iss_rd;
      wb_poison     <= go && pz_val;
      redirect_en   <= go && (iss_kind == OPK_CHECK) && pz_rd_val;
      redirect_addr <= iss_fixup;
    end
  end

  p_squash_r6: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !guard_val) |=> !commit_en && !wb_en && !redirect_en);

  p_redir_commit_r9: assert property (@(posedge clk) disable iff (rst)
    redirect_en |-> commit_en);

  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wb_en, redirect_en}));

  p_poison_tag_r8: assert property (@(posedge clk) disable iff (rst)
    wb_poison |-> wb_en);
endmodule

// File: rtl/pred_guard_unit.sv
module pred_guard_unit
  import pgu_pkg::*;
#(
  parameter int NPRED = 64,
  parameter int NGPR = 128,
  parameter int AW = 32,
  localparam int PIW = $clog2(NPRED),
  localparam int GIW = $clog2(NGPR)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmp_valid,
  input  logic [PIW-1:0] cmp_dst_t,
  input  logic [PIW-1:0] cmp_dst_f,
  input  logic           cmp_result,
  input  logic           iss_valid,
  input  logic [PIW-1:0] iss_qp,
  input  logic [1:0]     iss_kind,
  input  logic [GIW-1:0] iss_rd,
  input  logic           iss_fault,
  input  logic [AW-1:0]  iss_fixup,
  output logic           commit_en,
  output logic           wb_en,
  output logic [GIW-1:0] wb_rd,
  output logic           wb_poison,
  output logic           redirect_en,
  output logic [AW-1:0]  redirect_addr
);
  logic guard_val;
  logic pz_we;
  logic pz_val;
  logic pz_rd_val;

  pgu_flag_bank #(.NPRED(NPRED)) u_flags (
    .clk(clk), .rst(rst),
    .cmp_valid(cmp_valid), .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f),
    .cmp_result(cmp_result),
    .rd_idx(iss_qp), .rd_val(guard_val)
  );

  pgu_poison_bank #(.NGPR(NGPR)) u_poison (
    .clk(clk), .rst(rst),
    .we(pz_we), .wr_idx(iss_rd), .wr_val(pz_val),
    .rd_idx(iss_rd), .rd_val(pz_rd_val)
  );

  pgu_issue_gate #(.NGPR(NGPR), .AW(AW)) u_gate (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_kind(op_kind_e'(iss_kind)), .iss_rd(iss_rd),
    .iss_fault(iss_fault), .iss_fixup(iss_fixup),
    .guard_val(guard_val), .pz_rd_val(pz_rd_val),
    .pz_we(pz_we), .pz_val(pz_val),
    .commit_en(commit_en), .wb_en(wb_en), .wb_rd(wb_rd), .wb_poison(wb_poison),
    .redirect_en(redirect_en), .redirect_addr(redirect_addr)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !commit_en && !wb_en && !redirect_en);
endmodule

// File: tb/sim_pred_guard_unit.sv
`timescale 1ns/1ps
module sim_pred_guard_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_valid = 0, cmp_result = 0;
  logic [5:0] cmp_dst_t = 0, cmp_dst_f = 0, iss_qp = 0;
  logic iss_valid = 0, iss_fault = 0;
  logic [1:0] iss_kind = 0;
  logic [6:0] iss_rd = 0;
  logic [31:0] iss_fixup = 0;
  logic commit_en, wb_en, wb_poison, redirect_en;
  logic [6:0] wb_rd;
  logic [31:0] redirect_addr;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pred_guard_unit u0 (
    .clk(clk), .rst(rst),
    .cmp_valid(cmp_valid), .cmp_dst_t(cmp_dst_t), .cmp_dst_f(cmp_dst_f),
    .cmp_result(cmp_result),
    .iss_valid(iss_valid), .iss_qp(iss_qp), .iss_kind(iss_kind), .iss_rd(iss_rd),
    .iss_fault(iss_fault), .iss_fixup(iss_fixup),
    .commit_en(commit_en), .wb_en(wb_en), .wb_rd(wb_rd), .wb_poison(wb_poison),
    .redirect_en(redirect_en), .redirect_addr(redirect_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    cmp_valid = 0; cmp_dst_t = 0; cmp_dst_f = 0; cmp_result = 0;
    iss_valid = 0; iss_qp = 0; iss_kind = 0; iss_rd = 0; iss_fault = 0; iss_fixup = 0;
  endtask

  // one cycle: drive at negedge, edge, release, outputs observed at next negedge
  task automatic cycle(input logic cv, input logic [5:0] ct, input logic [5:0] cf,
                       input logic cr, input logic iv, input logic [5:0] qp,
                       input logic [1:0] k, input logic [6:0] rd, input logic flt,
                       input logic [31:0] fx);
    @(negedge clk);
    cmp_valid = cv; cmp_dst_t = ct; cmp_dst_f = cf; cmp_result = cr;
    iss_valid = iv; iss_qp = qp; iss_kind = k; iss_rd = rd; iss_fault = flt; iss_fixup = fx;
    @(posedge clk);
    #1 clear_inputs();
    @(negedge clk);
  endtask

  task automatic do_cmp(input logic [5:0] t, input logic [5:0] f, input logic r);
    cycle(1, t, f, r, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic probe(input string req, input logic [5:0] qp, input logic exp);
    cycle(0, 0, 0, 0, 1, qp, 2'd0, 0, 0, 0);
    check(req, commit_en, exp);
  endtask

  task automatic chk_op(input string req, input logic [6:0] rd, input logic exp_redir);
    cycle(0, 0, 0, 0, 1, 0, 2'd3, rd, 0, 32'hCAFE_0000 + rd);
    check(req, redirect_en, exp_redir);
    if (exp_redir) check(req, redirect_addr, 32'hCAFE_0000 + rd);
  endtask

  task automatic t_reset();
    check("R1 commit", commit_en, 0);
    check("R1 wb", wb_en, 0);
    check("R1 redirect", redirect_en, 0);
    probe("R1 flag5", 6'd5, 0);
    probe("R1 flag63", 6'd63, 0);
    chk_op("R1 poison", 7'd40, 0);
  endtask

  task automatic t_zero_flag();
    do_cmp(6'd0, 6'd7, 1'b0);
    probe("R2 flag0", 6'd0, 1);
    probe("R3 flag7", 6'd7, 1);
    do_cmp(6'd7, 6'd0, 1'b0);
    probe("R2 flag0 dst_f", 6'd0, 1);
    probe("R3 flag7 t", 6'd7, 0);
  endtask

  task automatic t_pair();
    do_cmp(6'd3, 6'd4, 1'b1);
    probe("R3 p3", 6'd3, 1);
    probe("R3 p4", 6'd4, 0);
    do_cmp(6'd63, 6'd1, 1'b0);
    probe("R3 p63", 6'd63, 0);
    probe("R3 p1", 6'd1, 1);
    probe("R3 p3 kept", 6'd3, 1);
  endtask

  task automatic t_bypass();
    cycle(1, 6'd9, 6'd10, 1'b1, 1, 6'd9, 2'd0, 0, 0, 0);
    check("R4 bypass t", commit_en, 1);
    cycle(1, 6'd11, 6'd12, 1'b1, 1, 6'd12, 2'd0, 0, 0, 0);
    check("R4 bypass f", commit_en, 0);
    cycle(1, 6'd13, 6'd14, 1'b0, 1, 6'd14, 2'd1, 7'd5, 0, 0);
    check("R4 bypass wb", wb_en, 1);
  endtask

  task automatic t_alias();
    do_cmp(6'd20, 6'd20, 1'b1);
    probe("R5 alias 1", 6'd20, 1);
    do_cmp(6'd20, 6'd20, 1'b0);
    probe("R5 alias 0", 6'd20, 0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    iss_valid = 1; iss_qp = 0; iss_kind = 2'd1; iss_rd = 7'd30;
    #1 check("R11 before edge", wb_en, 0);
    @(posedge clk);
    #1 clear_inputs();
    check("R11 after edge", wb_en, 1);
    check("R7 wb_rd", wb_rd, 7'd30);
    check("R7 poison0", wb_poison, 0);
  endtask

  task automatic t_spec();
    cycle(0, 0, 0, 0, 1, 0, 2'd2, 7'd21, 1, 0);
    check("R8 wb", wb_en, 1);
    check("R8 tag", wb_poison, 1);
    chk_op("R9 poisoned", 7'd21, 1);
    chk_op("R9 again", 7'd21, 1);
    chk_op("R9 clean", 7'd22, 0);
    cycle(0, 0, 0, 0, 1, 0, 2'd0, 7'd23, 0, 0);
    check("R9 kind0 nowb", wb_en, 0);
    cycle(0, 0, 0, 0, 1, 0, 2'd2, 7'd24, 0, 0);
    check("R8 nofault tag", wb_poison, 0);
    chk_op("R8 nofault", 7'd24, 0);
  endtask

  task automatic t_squash();
    // flag 4 is false here
    cycle(0, 0, 0, 0, 1, 6'd4, 2'd1, 7'd21, 0, 0);
    check("R6 commit", commit_en, 0);
    check("R6 wb", wb_en, 0);
    chk_op("R10 still poisoned", 7'd21, 1);
    cycle(0, 0, 0, 0, 1, 6'd4, 2'd2, 7'd22, 1, 0);
    check("R6 ld wb", wb_en, 0);
    chk_op("R10 ld off", 7'd22, 0);
    cycle(0, 0, 0, 0, 1, 6'd4, 2'd3, 7'd21, 0, 32'h1);
    check("R6 check off", redirect_en, 0);
    cycle(0, 0, 0, 0, 1, 6'd3, 2'd1, 7'd21, 0, 0);
    check("R7 write", wb_en, 1);
    chk_op("R7 cleared", 7'd21, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    t_reset();
    t_zero_flag();
    t_pair();
    t_bypass();
    t_alias();
    t_latency();
    t_spec();
    t_squash();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule